// File: doc/BRIEF.md
# Vectored Interrupt Event Controller

This block sits beside a small microcontroller core and turns five hardware event pulses into vectored interrupt requests. The sources are two divider overflows, two timer underflows and a change on an external port. Each source latches a bit in an 8-bit event flag register. Software owns an 8-bit enable register and a global enable latch. When a flagged event is also enabled and the global latch is open, the block takes the interrupt. It emits a one-cycle request together with the program address of the matching service routine. In the same cycle it clears that one event flag and closes the global latch.

The core drives single-cycle strobes into the block: write the enable register, enable interrupts, disable interrupts, clear event flags by immediate mask, and return from the service routine. It also drives a level that says it is in the low-power hold state. An interrupt taken during hold raises a wake pulse. The first return after that raises a pulse telling the core to go back into hold.

Top module: `irq_event_ctrl`

## Requirements
- R1: During and after a synchronous active-low reset, the event flags, the enable register, the global enable and all four outputs (`irq_req`, `irq_vec`, `hold_wake`, `hold_reenter`) are zero.
- R2: Each source pulse sets its flag on the next clock edge. The mapping from `src_evt` bits to flag bits is: `src_evt[0]`→bit 0, `src_evt[1]`→bit 1, `src_evt[2]`→bit 2, `src_evt[3]`→bit 4, `src_evt[4]`→bit 7. Flag bits 3, 5 and 6 always read as zero.
- R3: An interrupt is taken only if all three of these hold in the same cycle: a flag bit is set, the matching enable bit is set, and the global enable is 1. `irq_req` is then high for exactly one cycle, on the next edge.
- R4: `irq_vec` carries the service address while `irq_req` is high: bit 0 → 0x004, bit 1 → 0x008, bit 2 → 0x00C, bit 4 → 0x014, bit 7 → 0x020. It is 0x000 at all other times.
- R5: When several enabled flags are pending, the lowest bit index is served first.
- R6: Taking an interrupt clears only the flag of the served source. All other flags keep their values.
- R7: Taking an interrupt clears the global enable. The global enable is set again by an enable command or by a write to the enable register.
- R8: A disable command clears the global enable and wins over a simultaneous enable command or enable-register write. A simultaneous interrupt take also leaves the global enable cleared.
- R9: A clear-event command clears the flags selected by its mask. A source pulse in the same cycle as a clear of its own bit leaves that bit set.
- R10: An interrupt taken while `hold_mode` is 1 raises `hold_wake` in the same cycle as `irq_req`.
- R11: The first return strobe after a hold-woken interrupt raises `hold_reenter` for one cycle on the next edge. A return strobe with no pending hold wake has no effect on `hold_reenter`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_evt | input | 5 | Source event pulses (div0, tmr0, port, tmr1, div1) |
| ien_wr | input | 1 | Write strobe for the enable register; also opens the global enable |
| ien_wdata | input | 8 | Enable register write data |
| int_en | input | 1 | Enable-interrupts command |
| int_dis | input | 1 | Disable-interrupts command |
| evf_clr | input | 1 | Clear-event command |
| evf_clr_mask | input | 8 | Immediate mask of flag bits to clear |
| ret_strobe | input | 1 | Return-from-service-routine strobe |
| hold_mode | input | 1 | Core is in hold |
| irq_req | output | 1 | One-cycle interrupt request |
| irq_vec | output | 12 | Service routine address |
| hold_wake | output | 1 | Release hold for service |
| hold_reenter | output | 1 | Re-enter hold after return |
| evt_flags | output | 8 | Event flag register |
| glb_en | output | 1 | Global enable state |

## Verification
The hardest case to reach is the order in which several simultaneous events are served. It only shows up when several flags are pending while the global enable is closed. The stimulus gets there in three steps. It first takes one interrupt, which closes the enable. It then fires three sources while the enable stays closed. Finally it reopens the enable once per service, so that every take, vector and surviving flag set is visible. Same-cycle collisions are driven on purpose: set against clear, disable against enable, and a take against an enable command.

// File: rtl/irq_evt_pkg.sv
// Shared constants and mapping functions for the interrupt event controller.
// Assumes five sources mapped onto an 8-bit flag space.
package irq_evt_pkg;
    localparam int FLAG_W = 8;
    localparam int SRC_N  = 5;
    localparam int VEC_W  = 12;
    localparam logic [FLAG_W-1:0] USED_BITS = 8'h97;

    // Flag bit index for a given source number.
    function automatic int src_bit(input int s);
        case (s)
            0:       return 0;
            1:       return 1;
            2:       return 2;
            3:       return 4;
            default: return 7;
        endcase
    endfunction

    // Service address for a given flag bit index.
    function automatic logic [VEC_W-1:0] bit_vector(input int b);
        case (b)
            0:       return VEC_W'(12'h004);
            1:       return VEC_W'(12'h008);
            2:       return VEC_W'(12'h00C);
            4:       return VEC_W'(12'h014);
            7:       return VEC_W'(12'h020);
            default: return '0;
        endcase
    endfunction
endpackage

// File: rtl/irq_flag_bank.sv
// Event flag register. Source pulses set bits; the clear command and the
// interrupt take clear them; a set wins over any clear in the same cycle.
// Bits absent from USED are tied to zero.
module irq_flag_bank
    import irq_evt_pkg::*;
#(
    parameter int               FW   = FLAG_W,
    parameter int               SN   = SRC_N,
    parameter logic [FW-1:0]    USED = USED_BITS
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [SN-1:0] src_evt,
    input  logic          clr_cmd,
    input  logic [FW-1:0] clr_mask,
    input  logic [FW-1:0] take_mask,
    output logic [FW-1:0] flags
);
    logic [FW-1:0] set_m;
    logic [FW-1:0] kill_m;

    // Scatter source pulses onto their flag positions.
    always_comb begin
        set_m = '0;
        for (int s = 0; s < SN; s++) begin
            set_m[src_bit(s)] = set_m[src_bit(s)] | src_evt[s];
        end
        kill_m = (clr_cmd ? clr_mask : '0) | take_mask;
    end

    for (genvar b = 0; b < FW; b++) begin : g_bit
        if (USED[b]) begin : g_live
            // Per-bit flag: set has priority over clear.
            always_ff @(posedge clk) begin
                if (!rst_n)         flags[b] <= 1'b0;
                else if (set_m[b])  flags[b] <= 1'b1;
                else if (kill_m[b]) flags[b] <= 1'b0;
            end
        end else begin : g_tie
            assign flags[b] = 1'b0;
        end
    end

    a_r9_set_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
        src_evt[0] |=> flags[0]);
    a_r6_single_take: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(take_mask));
    a_r2_unused_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (flags & ~USED) == '0);
endmodule

// File: rtl/irq_gate_ctl.sv
// Enable register and global enable latch. The global latch closes on a
// take or a disable command and opens on an enable command or enable write.
module irq_gate_ctl
    import irq_evt_pkg::*;
#(
    parameter int FW = FLAG_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ien_wr,
    input  logic [FW-1:0] ien_wdata,
    input  logic          en_cmd,
    input  logic          dis_cmd,
    input  logic          take,
    output logic [FW-1:0] ien_q,
    output logic          gie_q
);
    // Software-written per-source enable register.
    always_ff @(posedge clk) begin
        if (!rst_n)      ien_q <= '0;
        else if (ien_wr) ien_q <= ien_wdata;
    end

    // Global enable: closing events win over opening events.
    always_ff @(posedge clk) begin
        if (!rst_n)               gie_q <= 1'b0;
        else if (take || dis_cmd) gie_q <= 1'b0;
        else if (en_cmd || ien_wr) gie_q <= 1'b1;
    end

    a_r8_dis_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        dis_cmd |=> !gie_q);
    a_r7_take_closes: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> !gie_q);
endmodule

// File: rtl/irq_arbiter.sv
// Combinational arbiter: finds enabled pending flags, picks the lowest
// index and forms its service address. Clock is used only by assertions.
module irq_arbiter
    import irq_evt_pkg::*;
#(
    parameter int FW = FLAG_W,
    parameter int VW = VEC_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [FW-1:0] flags,
    input  logic [FW-1:0] ien,
    input  logic          gie,
    output logic          take,
    output logic [FW-1:0] take_mask,
    output logic [VW-1:0] vec_next
);
    logic [FW-1:0] pending;
    logic [FW-1:0] grant;
    int            sel;

    // Lowest-index priority selection over enabled pending flags.
    always_comb begin
        pending = flags & ien;
        grant   = '0;
        sel     = 0;
        for (int i = FW - 1; i >= 0; i--) begin
            if (pending[i]) begin
                grant    = '0;
                grant[i] = 1'b1;
                sel      = i;
            end
        end
        take      = gie && (pending != '0);
        take_mask = take ? grant : '0;
        vec_next  = take ? bit_vector(sel) : '0;
    end

    a_r5_grant_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(take_mask));
    a_r3_take_needs_pending: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> ((take_mask & flags & ien) != '0));
endmodule

// File: rtl/irq_hold_ctl.sv
// Hold-mode helper: pulses wake when an interrupt is taken in hold, then
// pulses re-entry on the first return after that.
module irq_hold_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic take,
    input  logic hold_mode,
    input  logic ret_cmd,
    output logic wake_q,
    output logic reenter_q
);
    logic woke;

    // Remember that the current service routine interrupted hold.
    always_ff @(posedge clk) begin
        if (!rst_n)                 woke <= 1'b0;
        else if (take && hold_mode) woke <= 1'b1;
        else if (ret_cmd)           woke <= 1'b0;
    end

    // Registered wake and re-entry pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wake_q    <= 1'b0;
            reenter_q <= 1'b0;
        end else begin
            wake_q    <= take && hold_mode;
            reenter_q <= ret_cmd && woke;
        end
    end

    a_r10_wake_from_take: assert property (@(posedge clk) disable iff (!rst_n)
        wake_q |-> $past(take));
    a_r11_reenter_after_ret: assert property (@(posedge clk) disable iff (!rst_n)
        reenter_q |-> $past(ret_cmd));
endmodule

// File: rtl/irq_event_ctrl.sv
// Top of the interrupt event controller. Wires flag bank, gate control,
// arbiter and hold helper, and registers the request and vector.
// Assumes all command inputs are single-cycle strobes from the core.
module irq_event_ctrl
    import irq_evt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SRC_N-1:0]  src_evt,
    input  logic              ien_wr,
    input  logic [FLAG_W-1:0] ien_wdata,
    input  logic              int_en,
    input  logic              int_dis,
    input  logic              evf_clr,
    input  logic [FLAG_W-1:0] evf_clr_mask,
    input  logic              ret_strobe,
    input  logic              hold_mode,
    output logic              irq_req,
    output logic [VEC_W-1:0]  irq_vec,
    output logic              hold_wake,
    output logic              hold_reenter,
    output logic [FLAG_W-1:0] evt_flags,
    output logic              glb_en
);
    logic              take;
    logic [FLAG_W-1:0] take_mask;
    logic [FLAG_W-1:0] ien_q;
    logic [VEC_W-1:0]  vec_next;

    irq_flag_bank #(.FW(FLAG_W), .SN(SRC_N), .USED(USED_BITS)) u_flags (
        .clk(clk), .rst_n(rst_n), .src_evt(src_evt), .clr_cmd(evf_clr),
        .clr_mask(evf_clr_mask), .take_mask(take_mask), .flags(evt_flags)
    );

    irq_gate_ctl #(.FW(FLAG_W)) u_gate (
        .clk(clk), .rst_n(rst_n), .ien_wr(ien_wr), .ien_wdata(ien_wdata),
        .en_cmd(int_en), .dis_cmd(int_dis), .take(take),
        .ien_q(ien_q), .gie_q(glb_en)
    );

    irq_arbiter #(.FW(FLAG_W), .VW(VEC_W)) u_arb (
        .clk(clk), .rst_n(rst_n), .flags(evt_flags), .ien(ien_q), .gie(glb_en),
        .take(take), .take_mask(take_mask), .vec_next(vec_next)
    );

    irq_hold_ctl u_hold (
        .clk(clk), .rst_n(rst_n), .take(take), .hold_mode(hold_mode),
        .ret_cmd(ret_strobe), .wake_q(hold_wake), .reenter_q(hold_reenter)
    );

    // Register the request pulse and its service address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_req <= 1'b0;
            irq_vec <= '0;
        end else begin
            irq_req <= take;
            irq_vec <= vec_next;
        end
    end

    a_r3_req_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> $past(glb_en));
    a_r7_req_closes_gate: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> !glb_en);
    a_r4_vec_only_with_req: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_req |-> (irq_vec == '0));
    a_r10_wake_with_req: assert property (@(posedge clk) disable iff (!rst_n)
        hold_wake |-> irq_req);
endmodule

// File: tb/irq_event_ctrl_bench.sv
module irq_event_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  src_evt = '0;
    logic        ien_wr = 1'b0;
    logic [7:0]  ien_wdata = '0;
    logic        int_en = 1'b0;
    logic        int_dis = 1'b0;
    logic        evf_clr = 1'b0;
    logic [7:0]  evf_clr_mask = '0;
    logic        ret_strobe = 1'b0;
    logic        hold_mode = 1'b0;
    logic        irq_req;
    logic [11:0] irq_vec;
    logic        hold_wake;
    logic        hold_reenter;
    logic [7:0]  evt_flags;
    logic        glb_en;

    int checks = 0;
    int fails = 0;
    bit done = 0;
    string phase = "R1 reset";

    // Reference model state.
    int m_evt = 0, m_ien = 0, m_gie = 0, m_req = 0, m_vec = 0;
    int m_wake = 0, m_reh = 0, m_woke = 0;

    always #10 clk = ~clk;

    irq_event_ctrl u_irq_event_ctrl (
        .clk(clk), .rst_n(rst_n), .src_evt(src_evt), .ien_wr(ien_wr),
        .ien_wdata(ien_wdata), .int_en(int_en), .int_dis(int_dis),
        .evf_clr(evf_clr), .evf_clr_mask(evf_clr_mask), .ret_strobe(ret_strobe),
        .hold_mode(hold_mode), .irq_req(irq_req), .irq_vec(irq_vec),
        .hold_wake(hold_wake), .hold_reenter(hold_reenter),
        .evt_flags(evt_flags), .glb_en(glb_en)
    );

    function automatic int vec_of(input int b);
        if (b == 0) return 4;
        if (b == 1) return 8;
        if (b == 2) return 12;
        if (b == 4) return 20;
        if (b == 7) return 32;
        return 0;
    endfunction

    // Behavioural model advanced on each rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_evt = 0; m_ien = 0; m_gie = 0; m_req = 0; m_vec = 0;
            m_wake = 0; m_reh = 0; m_woke = 0;
        end else begin
            int pend, idx, take, setb, nevt;
            pend = m_evt & m_ien;
            idx = -1;
            for (int i = 7; i >= 0; i--) if ((pend >> i) & 1) idx = i;
            take = (m_gie != 0) && (pend != 0);
            setb = 0;
            if (src_evt[0]) setb |= 1;
            if (src_evt[1]) setb |= 2;
            if (src_evt[2]) setb |= 4;
            if (src_evt[3]) setb |= 16;
            if (src_evt[4]) setb |= 128;
            nevt = m_evt;
            if (evf_clr) nevt &= ~int'(evf_clr_mask);
            if (take) nevt &= ~(1 << idx);
            nevt = (nevt | setb) & 8'h97;
            if (take || int_dis) m_gie = 0;
            else if (int_en || ien_wr) m_gie = 1;
            if (ien_wr) m_ien = int'(ien_wdata);
            m_evt = nevt;
            m_req = take;
            m_vec = take ? vec_of(idx) : 0;
            m_wake = take && hold_mode;
            m_reh = ret_strobe && (m_woke != 0);
            if (take && hold_mode) m_woke = 1;
            else if (ret_strobe) m_woke = 0;
        end
    end

    task automatic cmp1(input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", phase, what, act, exp);
        end
    endtask

    task automatic compare();
        cmp1("irq_req", int'(irq_req), m_req);
        cmp1("irq_vec", int'(irq_vec), m_vec);
        cmp1("hold_wake", int'(hold_wake), m_wake);
        cmp1("hold_reenter", int'(hold_reenter), m_reh);
        cmp1("evt_flags", int'(evt_flags), m_evt);
        cmp1("glb_en", int'(glb_en), m_gie);
    endtask

    task automatic quiet();
        src_evt = '0; ien_wr = 0; int_en = 0; int_dis = 0;
        evf_clr = 0; ret_strobe = 0;
    endtask

    task automatic cyc(input int n = 1);
        for (int k = 0; k < n; k++) begin
            @(posedge clk);
            @(negedge clk);
            compare();
            quiet();
        end
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        // R1: reset state
        phase = "R1 reset";
        src_evt = 5'h1f; ien_wr = 1; ien_wdata = 8'hff; int_en = 1;
        cyc(3);
        rst_n = 1;
        cyc(2);

        // R2: each source maps to its flag; nothing is enabled yet
        phase = "R2 mapping";
        for (int s = 0; s < 5; s++) begin
            src_evt = 5'(1 << s);
            cyc(1);
        end
        cyc(1);

        // R9: masked clear, then set colliding with clear of the same bit
        phase = "R9 clear";
        evf_clr = 1; evf_clr_mask = 8'h06;
        cyc(1);
        evf_clr = 1; evf_clr_mask = 8'hff; src_evt = 5'b00001;
        cyc(2);
        evf_clr = 1; evf_clr_mask = 8'hff;
        cyc(1);

        // R3: enable bit zero blocks the request even with the gate open
        phase = "R3 enable gating";
        ien_wr = 1; ien_wdata = 8'h02;
        cyc(1);
        src_evt = 5'b00001;
        cyc(3);
        evf_clr = 1; evf_clr_mask = 8'hff;
        cyc(1);

        // R4: each source serviced in turn with its vector
        phase = "R4 vectors";
        for (int s = 0; s < 5; s++) begin
            ien_wr = 1; ien_wdata = 8'h97;
            cyc(1);
            src_evt = 5'(1 << s);
            cyc(3);
        end

        // R5 / R6 / R7: several pending while closed, served lowest first
        phase = "R5 priority";
        src_evt = 5'b10110;
        cyc(3);
        phase = "R7 reopen";
        int_en = 1;
        cyc(3);
        phase = "R6 single clear";
        int_en = 1;
        cyc(3);
        int_en = 1;
        cyc(3);

        // R8: disable against enable, take against enable
        phase = "R8 collisions";
        int_en = 1; int_dis = 1;
        cyc(1);
        ien_wr = 1; ien_wdata = 8'h97; int_dis = 1;
        cyc(1);
        int_en = 1;
        cyc(1);
        src_evt = 5'b00010;
        cyc(1);
        int_en = 1;
        cyc(2);

        // R10 / R11: wake from hold and re-entry on return
        phase = "R10 hold wake";
        hold_mode = 1; int_en = 1;
        cyc(1);
        src_evt = 5'b00100;
        cyc(3);
        hold_mode = 0;
        phase = "R11 reenter";
        ret_strobe = 1;
        cyc(2);
        ret_strobe = 1;
        cyc(2);
        ret_strobe = 1; hold_mode = 0; int_en = 1;
        cyc(1);
        src_evt = 5'b01000;
        cyc(3);
        ret_strobe = 1;
        cyc(2);

        done = 1;
        finish_run();
    end
endmodule